// File: doc/BRIEF.md
# Shared-Bus Microcoded Datapath

This block is the datapath of a small microprogrammed processor. Every value moves over one 32-bit internal bus. In each micro-step, an external sequencer presents a flat control word. One source places a value on the bus: the ALU output, a register-file read, the immediate generator or the memory read data. Any number of load strobes then capture that value at the next rising clock edge. The candidate destinations are the A, B and memory-address latches, the instruction latch and a register-file write.

The register file holds 32 words. Entry 0 always reads as zero. Entry 31 serves as the program counter. A register port can address one of three fields of the instruction latch, or the program-counter entry. The instruction latch supplies the opcode to the sequencer. The ALU supplies a condition flag for compare operations.

Toward memory, the block presents the memory-address latch as the address and the bus as the write data, together with read and write qualifiers. While a read is outstanding and memory reports busy, the block freezes all of its state. The sequencer can then hold the same control word until the data arrives.

Top module: `sbdp_top`

## Requirements
- R1: After synchronous reset, all latches and register entries are zero. The address output, the opcode and the program counter therefore read 0.
- R2: The bus is the value of the single enabled source. The sources are `alu_en`, register read (`reg_en`=1 with `reg_wr`=0), `imm_en`, and memory read (`mem_en`=1 with `mem_wr`=0). With no source enabled the bus is 0. `mem_wdata` always shows the bus, in the same cycle. At most one source may be enabled in any cycle.
- R3: A register read places one entry on the bus. `reg_sel` picks the entry: 0 takes instruction bits [19:15], 1 takes bits [24:20], 2 takes bits [11:7], and 3 takes entry 31 (the program counter).
- R4: When `reg_wr`=1, the entry picked by `reg_sel` takes the bus value at the next edge. Writes to entry 0 are ignored, so it keeps reading 0.
- R5: `a_ld`, `b_ld`, `ma_ld` and `ir_ld` each capture the bus at the next edge. `mem_addr` shows the memory-address latch. `opcode` shows bits [6:0] of the instruction latch. A latch without its strobe keeps its value.
- R6: With `imm_en`=1, `imm_sel` drives one of four immediates from the instruction latch onto the bus: 0 is I-type, 1 is B-type, 2 is J-type and 3 is U-type. The I, B and J immediates are sign-extended from bit 31.
- R7: With `alu_en`=1, `alu_op` selects the ALU result from A and B. The codes are 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift-left, 6 logical right, 7 arithmetic right, 8 signed less-than, 9 unsigned less-than, 10 A+4, 11 A-4, 12 equal, 13 not-equal, 14 signed greater-or-equal and 15 unsigned greater-or-equal. Shifts use B[4:0]. Compare codes yield 0 or 1.
- R8: `cond` is the result of the compare selected by `alu_op` (codes 8, 9 and 12 to 15). For all other codes it is 0. It follows A, B and `alu_op` combinationally.
- R9: `mem_rd` is `mem_en` with `mem_wr`=0, and memory read data then drives the bus. `mem_we` is `mem_en` with `mem_wr`=1. During a write the memory does not drive the bus, so the write data comes from another source.
- R10: While `mem_rd`=1 and `mem_busy`=1, no load strobe and no register write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 4 | ALU operation code |
| alu_en | input | 1 | ALU drives bus |
| reg_sel | input | 2 | Register address source |
| reg_wr | input | 1 | Register write from bus |
| reg_en | input | 1 | Register read onto bus (when not writing) |
| imm_sel | input | 2 | Immediate format |
| imm_en | input | 1 | Immediate drives bus |
| a_ld | input | 1 | Load A from bus |
| b_ld | input | 1 | Load B from bus |
| ma_ld | input | 1 | Load memory address from bus |
| ir_ld | input | 1 | Load instruction latch from bus |
| mem_wr | input | 1 | Memory access is a write |
| mem_en | input | 1 | Memory access enable |
| mem_busy | input | 1 | Memory not ready |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address latch |
| mem_wdata | output | 32 | Bus value, used as write data |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| opcode | output | 7 | Instruction bits [6:0] |
| cond | output | 1 | ALU compare result |

## Verification
The bus value, `mem_wdata`, `cond`, `mem_rd` and `mem_we` are combinational. The bench samples them 1 ns after it changes the control inputs, within the same cycle. Latches and register entries change at the next rising edge. The bench therefore checks `mem_addr`, `opcode` and read-backs after one full tick, and reads a register back in the following micro-step. The stall check holds busy across an edge, then looks for unchanged outputs before releasing busy.

// File: rtl/sbdp_pkg.sv
package sbdp_pkg;
    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RAW    = $clog2(NREGS);
    localparam int PC_IDX = NREGS - 1;
    localparam int OPW    = 7;
    localparam int SHW    = $clog2(XLEN);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  ridx_t;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,  ALU_SUB  = 4'd1,  ALU_AND  = 4'd2,  ALU_OR   = 4'd3,
        ALU_XOR  = 4'd4,  ALU_SLL  = 4'd5,  ALU_SRL  = 4'd6,  ALU_SRA  = 4'd7,
        ALU_SLT  = 4'd8,  ALU_SLTU = 4'd9,  ALU_INC4 = 4'd10, ALU_DEC4 = 4'd11,
        ALU_EQ   = 4'd12, ALU_NE   = 4'd13, ALU_GE   = 4'd14, ALU_GEU  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        RSRC_RS1 = 2'd0, RSRC_RS2 = 2'd1, RSRC_RD = 2'd2, RSRC_PC = 2'd3
    } reg_src_e;

    typedef enum logic [1:0] {
        IMM_I = 2'd0, IMM_B = 2'd1, IMM_J = 2'd2, IMM_U = 2'd3
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      alu_en;
        reg_src_e  reg_sel;
        logic      reg_wr;
        logic      reg_en;
        imm_kind_e imm_sel;
        logic      imm_en;
        logic      a_ld;
        logic      b_ld;
        logic      ma_ld;
        logic      ir_ld;
        logic      mem_wr;
        logic      mem_en;
    } ctrl_t;

    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
        ridx_t rd;
    } ir_fields_t;

    function automatic ir_fields_t split_ir(word_t ir);
        ir_fields_t f;
        f.rs1 = ir[19:15];
        f.rs2 = ir[24:20];
        f.rd  = ir[11:7];
        return f;
    endfunction

    function automatic logic is_compare(alu_op_e op);
        return (op == ALU_SLT) || (op == ALU_SLTU) || (op == ALU_EQ) ||
               (op == ALU_NE)  || (op == ALU_GE)   || (op == ALU_GEU);
    endfunction
endpackage

// File: rtl/sbdp_regfile.sv
module sbdp_regfile
    import sbdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t addr,
    input  word_t wdata,
    output word_t rdata
);
    word_t store [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign store[i] = '0;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    store[i] <= '0;
                else if (we && addr == ridx_t'(i))
                    store[i] <= wdata;
            end
        end
    end

    assign rdata = store[addr];
endmodule

// File: rtl/sbdp_immgen.sv
module sbdp_immgen
    import sbdp_pkg::*;
(
    input  word_t     ir,
    input  imm_kind_e kind,
    output word_t     imm
);
    always_comb begin
        unique case (kind)
            IMM_I:   imm = {{20{ir[31]}}, ir[31:20]};
            IMM_B:   imm = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
            IMM_J:   imm = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
            IMM_U:   imm = {ir[31:12], 12'b0};
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/sbdp_alu.sv
module sbdp_alu
    import sbdp_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y,
    output logic    cond
);
    logic eq, lt, ltu;
    logic [SHW-1:0] sh;

    always_comb begin
        eq  = (a == b);
        lt  = ($signed(a) < $signed(b));
        ltu = (a < b);
        sh  = b[SHW-1:0];
        cond = 1'b0;
        unique case (op)
            ALU_SLT:  cond = lt;
            ALU_SLTU: cond = ltu;
            ALU_EQ:   cond = eq;
            ALU_NE:   cond = !eq;
            ALU_GE:   cond = !lt;
            ALU_GEU:  cond = !ltu;
            default:  cond = 1'b0;
        endcase
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLL:  y = a << sh;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = word_t'($signed(a) >>> sh);
            ALU_INC4: y = a + word_t'(4);
            ALU_DEC4: y = a - word_t'(4);
            default:  y = {{(XLEN-1){1'b0}}, cond};
        endcase
        if (is_compare(op))
            y = {{(XLEN-1){1'b0}}, cond};
    end
endmodule

// File: rtl/sbdp_top.sv
module sbdp_top
    import sbdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  alu_op,
    input  logic        alu_en,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_en,
    input  logic [1:0]  imm_sel,
    input  logic        imm_en,
    input  logic        a_ld,
    input  logic        b_ld,
    input  logic        ma_ld,
    input  logic        ir_ld,
    input  logic        mem_wr,
    input  logic        mem_en,
    input  logic        mem_busy,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_rd,
    output logic        mem_we,
    output logic [6:0]  opcode,
    output logic        cond
);
    ctrl_t      c;
    word_t      bus, a_q, b_q, ma_q, ir_q;
    word_t      alu_y, imm_v, rf_q;
    ir_fields_t fld;
    ridx_t      raddr;
    logic       stall;

    always_comb begin
        c.alu_op  = alu_op_e'(alu_op);
        c.alu_en  = alu_en;
        c.reg_sel = reg_src_e'(reg_sel);
        c.reg_wr  = reg_wr;
        c.reg_en  = reg_en;
        c.imm_sel = imm_kind_e'(imm_sel);
        c.imm_en  = imm_en;
        c.a_ld    = a_ld;
        c.b_ld    = b_ld;
        c.ma_ld   = ma_ld;
        c.ir_ld   = ir_ld;
        c.mem_wr  = mem_wr;
        c.mem_en  = mem_en;
    end

    assign mem_rd = c.mem_en && !c.mem_wr;
    assign mem_we = c.mem_en && c.mem_wr;
    assign stall  = mem_rd && mem_busy;

    assign fld = split_ir(ir_q);

    always_comb begin
        unique case (c.reg_sel)
            RSRC_RS1: raddr = fld.rs1;
            RSRC_RS2: raddr = fld.rs2;
            RSRC_RD:  raddr = fld.rd;
            default:  raddr = ridx_t'(PC_IDX);
        endcase
    end

    sbdp_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (c.reg_wr && !stall),
        .addr  (raddr),
        .wdata (bus),
        .rdata (rf_q)
    );

    sbdp_immgen u_imm (
        .ir   (ir_q),
        .kind (c.imm_sel),
        .imm  (imm_v)
    );

    sbdp_alu u_alu (
        .op   (c.alu_op),
        .a    (a_q),
        .b    (b_q),
        .y    (alu_y),
        .cond (cond)
    );

    // Shared bus: OR of gated sources; the sequencer keeps them exclusive.
    always_comb begin
        bus = '0;
        if (c.alu_en)                bus = bus | alu_y;
        if (c.reg_en && !c.reg_wr)   bus = bus | rf_q;
        if (c.imm_en)                bus = bus | imm_v;
        if (mem_rd)                  bus = bus | mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            ma_q <= '0;
            ir_q <= '0;
        end else if (!stall) begin
            if (c.a_ld)  a_q  <= bus;
            if (c.b_ld)  b_q  <= bus;
            if (c.ma_ld) ma_q <= bus;
            if (c.ir_ld) ir_q <= bus;
        end
    end

    assign mem_addr  = ma_q;
    assign mem_wdata = bus;
    assign opcode    = ir_q[OPW-1:0];
endmodule

// File: rtl/sbdp_chk.sv
module sbdp_chk (
    input logic        clk,
    input logic        rst,
    input logic        alu_en,
    input logic        reg_en,
    input logic        reg_wr,
    input logic        imm_en,
    input logic        mem_en,
    input logic        mem_wr,
    input logic        ma_ld,
    input logic        ir_ld,
    input logic        mem_busy,
    input logic [31:0] mem_rdata,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_rd,
    input logic        mem_we,
    input logic [6:0]  opcode
);
    logic [3:0] drv;
    assign drv = {alu_en, reg_en && !reg_wr, imm_en, mem_en && !mem_wr};

    a_r2_single_driver: assert property (@(posedge clk) disable iff (rst)
        $countones(drv) <= 1);

    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        (drv == 4'b0) |-> (mem_wdata == 32'd0));

    a_r9_read_data_on_bus: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_wr && drv == 4'b0001) |-> (mem_wdata == mem_rdata && mem_rd && !mem_we));

    a_r5_ma_capture: assert property (@(posedge clk) disable iff (rst)
        (ma_ld && !(mem_rd && mem_busy)) |=> (mem_addr == $past(mem_wdata)));

    a_r5_ma_hold: assert property (@(posedge clk) disable iff (rst)
        !ma_ld |=> $stable(mem_addr));

    a_r10_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_busy) |=> ($stable(mem_addr) && $stable(opcode)));

    a_r5_ir_capture: assert property (@(posedge clk) disable iff (rst)
        (ir_ld && !(mem_rd && mem_busy)) |=> (opcode == $past(mem_wdata[6:0])));
endmodule

bind sbdp_top sbdp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_en    (alu_en),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .imm_en    (imm_en),
    .mem_en    (mem_en),
    .mem_wr    (mem_wr),
    .ma_ld     (ma_ld),
    .ir_ld     (ir_ld),
    .mem_busy  (mem_busy),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .opcode    (opcode)
);

// File: tb/sbdp_top_tb.sv
module sbdp_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  alu_op = '0;
    logic        alu_en = 0, reg_wr = 0, reg_en = 0, imm_en = 0;
    logic [1:0]  reg_sel = '0, imm_sel = '0;
    logic        a_ld = 0, b_ld = 0, ma_ld = 0, ir_ld = 0;
    logic        mem_wr = 0, mem_en = 0, mem_busy = 0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_we, cond;
    logic [6:0]  opcode;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sbdp_top u_dut (
        .clk(clk), .rst(rst), .alu_op(alu_op), .alu_en(alu_en), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_en(reg_en), .imm_sel(imm_sel), .imm_en(imm_en),
        .a_ld(a_ld), .b_ld(b_ld), .ma_ld(ma_ld), .ir_ld(ir_ld), .mem_wr(mem_wr),
        .mem_en(mem_en), .mem_busy(mem_busy), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_we(mem_we), .opcode(opcode), .cond(cond)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic clr();
        alu_en = 0; reg_wr = 0; reg_en = 0; imm_en = 0;
        a_ld = 0; b_ld = 0; ma_ld = 0; ir_ld = 0;
        mem_wr = 0; mem_en = 0; mem_busy = 0;
        reg_sel = '0; imm_sel = '0; alu_op = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Memory read drives the bus; chosen latches capture it.
    task automatic mload(input logic [31:0] v, input logic la, input logic lb,
                         input logic lma, input logic lir);
        clr();
        mem_en = 1; mem_rdata = v;
        a_ld = la; b_ld = lb; ma_ld = lma; ir_ld = lir;
        tick();
        clr();
    endtask

    task automatic reg_write_rd(input int k, input logic [31:0] v);
        mload(32'(k) << 7, 0, 0, 0, 1);
        mem_en = 1; mem_rdata = v; reg_sel = 2'd2; reg_wr = 1;
        tick();
        clr();
    endtask

    function automatic logic [32:0] alu_model(input int op, input logic [31:0] a,
                                               input logic [31:0] b);
        logic c;
        logic [31:0] y;
        c = 0;
        y = 0;
        case (op)
            0:  y = a + b;
            1:  y = a - b;
            2:  y = a & b;
            3:  y = a | b;
            4:  y = a ^ b;
            5:  y = a << b[4:0];
            6:  y = a >> b[4:0];
            7:  y = 32'($signed(a) >>> b[4:0]);
            8:  c = $signed(a) < $signed(b);
            9:  c = a < b;
            10: y = a + 32'd4;
            11: y = a - 32'd4;
            12: c = (a == b);
            13: c = (a != b);
            14: c = !($signed(a) < $signed(b));
            default: c = !(a < b);
        endcase
        if (op == 8 || op == 9 || op >= 12) y = {31'b0, c};
        return {c, y};
    endfunction

    function automatic logic [31:0] imm_model(input int kind, input logic [31:0] ir);
        logic [31:0] r;
        case (kind)
            0: r = 32'($signed(ir) >>> 20);
            1: r = (ir[31] ? 32'hFFFF_F000 : 32'h0) + (32'(ir[7]) << 11)
                   + (32'(ir[30:25]) << 5) + (32'(ir[11:8]) << 1);
            2: r = (ir[31] ? 32'hFFF0_0000 : 32'h0) + (32'(ir[19:12]) << 12)
                   + (32'(ir[20]) << 11) + (32'(ir[30:21]) << 1);
            default: r = ir & 32'hFFFF_F000;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] pat(input int k);
        return 32'h9E37_79B9 * 32'(k + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] opa [6];
        logic [31:0] opb [6];
        logic [31:0] irs [6];
        logic [32:0] e;
        logic [6:0]  op_keep;
        opa = '{32'h0000_0005, 32'hFFFF_FFFB, 32'h8000_0000, 32'h1234_5678, 32'h7FFF_FFFF, 32'hA5A5_A5A5};
        opb = '{32'h0000_0003, 32'h0000_0005, 32'h0000_001F, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0024};
        irs = '{32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_F000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0FFF};

        clr();
        repeat (3) tick();
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 mem_addr", mem_addr, 32'd0);
        chk("R1 opcode", 32'(opcode), 32'd0);
        // R2: idle bus reads zero
        chk("R2 idle bus", mem_wdata, 32'd0);
        reg_en = 1; reg_sel = 2'd3; #1;
        chk("R1 pc zero", mem_wdata, 32'd0);
        clr();

        // R4 / R3: write every entry through rd, read back through each selector
        for (int k = 0; k < 32; k++) reg_write_rd(k, pat(k));
        for (int k = 0; k < 32; k++) begin
            logic [31:0] ex;
            ex = (k == 0) ? 32'd0 : pat(k);
            mload(32'(k) << 15, 0, 0, 0, 1);
            reg_en = 1; reg_sel = 2'd0; #1;
            chk("R3 rs1 read", mem_wdata, ex);
            clr();
            mload(32'(k) << 20, 0, 0, 0, 1);
            reg_en = 1; reg_sel = 2'd1; #1;
            chk("R3 rs2 read", mem_wdata, ex);
            clr();
            mload(32'(k) << 7, 0, 0, 0, 1);
            reg_en = 1; reg_sel = 2'd2; #1;
            chk("R4 rd readback", mem_wdata, ex);
            clr();
        end
        reg_en = 1; reg_sel = 2'd3; #1;
        chk("R3 pc is entry 31", mem_wdata, pat(31));
        clr();

        // R6: immediates
        for (int i = 0; i < 6; i++) begin
            mload(irs[i], 0, 0, 0, 1);
            for (int kd = 0; kd < 4; kd++) begin
                imm_en = 1; imm_sel = 2'(kd); #1;
                chk("R6 immediate", mem_wdata, imm_model(kd, irs[i]));
            end
            clr();
        end

        // R7 / R8: ALU sweep
        for (int p = 0; p < 6; p++) begin
            mload(opa[p], 1, 0, 0, 0);
            mload(opb[p], 0, 1, 0, 0);
            for (int op = 0; op < 16; op++) begin
                e = alu_model(op, opa[p], opb[p]);
                alu_en = 1; alu_op = 4'(op); #1;
                chk("R7 alu result", mem_wdata, e[31:0]);
                chk("R8 cond", 32'(cond), 32'(e[32]));
                alu_en = 0; #1;
                chk("R8 cond without bus", 32'(cond), 32'(e[32]));
            end
            clr();
        end

        // R9: memory write drives ALU result to MA address
        mload(32'h0000_0040, 0, 0, 1, 0);
        mload(32'h0000_1000, 1, 0, 0, 0);
        mload(32'h0000_0234, 0, 1, 0, 0);
        mem_en = 1; mem_wr = 1; alu_en = 1; alu_op = 4'd0; #1;
        chk("R9 write strobe", {30'b0, mem_we, mem_rd}, 32'd2);
        chk("R9 write addr", mem_addr, 32'h0000_0040);
        chk("R9 write data", mem_wdata, 32'h0000_1234);
        clr();
        mem_en = 1; mem_rdata = 32'hCAFE_F00D; #1;
        chk("R9 read strobe", {30'b0, mem_we, mem_rd}, 32'd1);
        chk("R9 read data on bus", mem_wdata, 32'hCAFE_F00D);
        clr();

        // R10: busy freezes latches and register writes
        mload(32'h0000_0013, 0, 0, 0, 1);
        op_keep = opcode;
        mem_en = 1; mem_busy = 1; mem_rdata = 32'h0000_0077; ir_ld = 1; ma_ld = 1;
        reg_sel = 2'd3; reg_wr = 1;
        tick();
        chk("R10 opcode frozen", 32'(opcode), 32'(op_keep));
        chk("R10 ma frozen", mem_addr, 32'h0000_0040);
        clr();
        reg_en = 1; reg_sel = 2'd3; #1;
        chk("R10 pc not written", mem_wdata, pat(31));
        clr();
        mem_en = 1; mem_rdata = 32'h0000_0077; ir_ld = 1;
        tick();
        clr();
        chk("R10 load after busy", 32'(opcode), 32'h77);

        // R5: fetch-style sequence
        reg_write_rd(31, 32'h0000_0100);
        reg_en = 1; reg_sel = 2'd3; ma_ld = 1; a_ld = 1;
        tick();
        clr();
        chk("R5 ma from pc", mem_addr, 32'h0000_0100);
        alu_en = 1; alu_op = 4'd10; reg_sel = 2'd3; reg_wr = 1;
        tick();
        clr();
        mload(32'h00B5_0533, 0, 0, 0, 1);
        chk("R5 opcode", 32'(opcode), 32'h33);
        chk("R5 ma held", mem_addr, 32'h0000_0100);
        reg_en = 1; reg_sel = 2'd3; #1;
        chk("R4 pc incremented", mem_wdata, 32'h0000_0104);
        clr();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule